// File: doc/BRIEF.md
# Adjustable Fractional-Delay Filter Datapath

This block is a single-rate fixed-point filter whose effective delay is set by a set of constant coefficients. One signed sample enters on every rising clock edge. Several parallel linear-phase FIR subfilters each produce a partial result. Each partial result is rounded and clamped to a narrower width. The partial results are then folded together through constant gains in a nested chain, and one signed word leaves the block per clock.

The subfilters have no private storage. One common shift register holds every delayed copy of the input, from the live sample up to the deepest delay that any stage needs. Stage `s` starts reading that register `s*PRE_STEP` positions down and takes eight consecutive taps from there. Inside each subfilter, pairs of mirrored taps are pre-added or pre-subtracted. This leaves four constant products, which a four-operand carry-save adder sums with two guard bits. The combining chain starts from stage 0. At each later stage, the running value is scaled by a constant gain, rounded, clamped, and added to that stage's quantized output with saturation.

Top module: `frac_delay_filter`

## Requirements
- R1: Reset is synchronous and active high. After any clock edge with `rst` high, `y_out` reads 0. Samples presented before or during that edge have no further effect on the output.
- R2: A sample on `x_in` at rising edge n first shows on `y_out` after edge n+1. The output stays 0 until a nonzero sample has been taken in.
- R3: All stages tap one shared delay line of depth DEPTH = (NSTG-1)*PRE_STEP+7 (11 by default). Stage s reads the input delayed by s*PRE_STEP through s*PRE_STEP+7. After DEPTH+1 consecutive zero samples the output returns to 0.
- R4: Each subfilter weights its tap k (k = 0..7, counted from the stage predelay) by an integer coefficient over 512. Even stages use the symmetric set 1,-8,34,156,156,34,-8,1. Odd stages use the antisymmetric set 1,-8,34,156,-156,-34,8,-1.
- R5: Each subfilter sum is requantized by adding 256 and shifting right arithmetically by 9, so an exact half rounds toward plus infinity. The result is clamped to the 11-bit range [-1024, 1023].
- R6: The combining chain runs as follows. Start with acc = q0. For s = 1..4 in that order: m = clamp12(floor((acc*g_s + 2)/4)), then acc = clamp12(m + q_s). The gains g_s are 7, -2, 2, -1 quarters (1.75, -0.5, 0.5, -0.25). `y_out` is the final acc.
- R7: Every clamp in the chain is to the 12-bit range [-2048, 2047]. A full-scale step saturates the output adder rather than wrapping.
- R8: Input and output are two's-complement words. The most negative input, -2048, is handled exactly. An input held constant for DEPTH+3 cycles gives an unchanging output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one sample per edge |
| rst | input | 1 | Synchronous active-high reset of the delay line and all registers |
| x_in | input | IN_W (12) | Signed input sample |
| y_out | output | OUT_W (12) | Signed filtered output, registered |

## Verification
The subfilter quantizer clamp and the saturating adder in the combining chain can act in the same cycle. A full-scale positive step provokes this: stage 0 overflows its 11-bit range just as the delayed antisymmetric stage 1 peaks, and the 1.75 gain pushes the stage-1 sum past 2047. The bench judges each output word against an independent bit-true model of the rounding and clamp sequence, aligned to the one-register latency. Impulses at both extremes, exact-half rounding inputs, a pseudo-random full-range stream and a reset in mid-stream cover the remaining behaviour.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

    // Tap count per subfilter: four mirrored pairs feed the four-operand adder.
    localparam int NTAP  = 8;
    localparam int NHALF = NTAP / 2;

    // First half of the subfilter coefficient set, scaled by 2**9.
    function automatic int half_tap(input int k);
        case (k)
            0:       return 1;
            1:       return -8;
            2:       return 34;
            default: return 156;
        endcase
    endfunction

    // Gain applied to the running value before stage s joins (quarters).
    function automatic int link_gain(input int s);
        case ((s - 1) % 4)
            0:       return 7;
            1:       return -2;
            2:       return 2;
            default: return -1;
        endcase
    endfunction

    // Even stages are symmetric, odd stages antisymmetric.
    function automatic bit stage_even(input int s);
        return (s % 2) == 0;
    endfunction

endpackage

// File: rtl/fdf_delay_line.sv
module fdf_delay_line #(
    parameter int W     = 12,
    parameter int DEPTH = 11
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [W-1:0]           din,
    output logic [DEPTH:0][W-1:0]  taps
);

    typedef struct packed {
        logic [DEPTH:1][W-1:0] pipe;
    } dl_t;

    dl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[1] = din;
        for (int k = 2; k <= DEPTH; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // Position 0 is the live sample, position k the sample k edges old.
    assign taps = {st_q.pipe, din};

endmodule

// File: rtl/fdf_add4.sv
module fdf_add4 #(
    parameter int W = 22
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic signed [W-1:0] c,
    input  logic signed [W-1:0] d,
    output logic signed [W+1:0] sum
);

    localparam int XW = W + 2;   // two guard bits cover four operands

    logic [XW-1:0] ea, eb, ec, ed;
    logic [XW-1:0] s1, c1, s2, c2;

    assign ea = XW'(a);
    assign eb = XW'(b);
    assign ec = XW'(c);
    assign ed = XW'(d);

    // First 3:2 compression
    assign s1 = ea ^ eb ^ ec;
    assign c1 = ((ea & eb) | (ea & ec) | (eb & ec)) << 1;

    // Second 3:2 compression folds in the fourth operand
    assign s2 = s1 ^ c1 ^ ed;
    assign c2 = ((s1 & c1) | (s1 & ed) | (c1 & ed)) << 1;

    // Single carry-propagate addition at the end
    assign sum = $signed(s2 + c2);

endmodule

// File: rtl/fdf_subfilter.sv
module fdf_subfilter
    import fdf_pkg::*;
#(
    parameter int W    = 12,
    parameter int CW   = 9,
    parameter int FRAC = 9,
    parameter int QW   = 11,
    parameter bit SYM  = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NTAP-1:0][W-1:0] win,
    output logic signed [QW-1:0]   q
);

    localparam int PW = W + 1;        // pre-added pair
    localparam int MW = PW + CW;      // constant product
    localparam int SW = MW + 2;       // four-operand sum
    localparam int RW = SW + 1;       // room for rounding offset

    localparam logic signed [RW-1:0] HALF = RW'(2 ** (FRAC - 1));
    localparam logic signed [RW-1:0] QHI  = RW'(2 ** (QW - 1) - 1);
    localparam logic signed [RW-1:0] QLO  = -QHI - RW'(1);

    typedef struct packed {
        logic signed [QW-1:0] q;
    } sf_t;

    sf_t st_d, st_q;

    logic [NHALF-1:0][MW-1:0] pp;
    logic signed [SW-1:0]     sum;
    logic signed [RW-1:0]     rnd, shr;

    for (genvar h = 0; h < NHALF; h++) begin : g_pair
        localparam logic signed [CW-1:0] HC = CW'(half_tap(h));
        logic signed [PW-1:0] pr;
        logic signed [MW-1:0] prod;
        if (SYM) begin : g_sym
            assign pr = PW'($signed(win[h])) + PW'($signed(win[NTAP-1-h]));
        end else begin : g_anti
            assign pr = PW'($signed(win[h])) - PW'($signed(win[NTAP-1-h]));
        end
        assign prod  = pr * HC;
        assign pp[h] = prod;
    end

    fdf_add4 #(.W(MW)) u_add4 (
        .a   (pp[0]),
        .b   (pp[1]),
        .c   (pp[2]),
        .d   (pp[3]),
        .sum (sum)
    );

    always_comb begin
        st_d = st_q;
        rnd  = RW'(sum) + HALF;
        shr  = rnd >>> FRAC;
        if (shr > QHI) begin
            st_d.q = QHI[QW-1:0];
        end else if (shr < QLO) begin
            st_d.q = QLO[QW-1:0];
        end else begin
            st_d.q = shr[QW-1:0];
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.q;

endmodule

// File: rtl/fdf_combine.sv
module fdf_combine
    import fdf_pkg::*;
#(
    parameter int NSTG = 5,
    parameter int QW   = 11,
    parameter int AW   = 12,
    parameter int GW   = 4,
    parameter int MF   = 2
) (
    input  logic [NSTG-1:0][QW-1:0] qv,
    output logic signed [AW-1:0]    mix
);

    localparam int PW = AW + GW;
    localparam int RW = PW + 1;

    localparam logic signed [RW-1:0] HALF = RW'(2 ** (MF - 1));
    localparam logic signed [RW-1:0] MHI  = RW'(2 ** (AW - 1) - 1);
    localparam logic signed [RW-1:0] MLO  = -MHI - RW'(1);
    localparam logic signed [AW:0]   SHI  = (AW + 1)'(2 ** (AW - 1) - 1);
    localparam logic signed [AW:0]   SLO  = -SHI - (AW + 1)'(1);

    logic [NSTG-1:0][AW-1:0] acc;

    assign acc[0] = AW'($signed(qv[0]));

    for (genvar s = 1; s < NSTG; s++) begin : g_link
        localparam logic signed [GW-1:0] G = GW'(link_gain(s));
        logic signed [PW-1:0] prod;
        logic signed [RW-1:0] prnd, pshr;
        logic        [AW-1:0] mval;
        logic signed [AW:0]   tot;

        assign prod = $signed(acc[s-1]) * G;
        assign prnd = RW'(prod) + HALF;
        assign pshr = prnd >>> MF;
        assign mval = (pshr > MHI) ? MHI[AW-1:0] :
                      (pshr < MLO) ? MLO[AW-1:0] : pshr[AW-1:0];
        assign tot  = (AW + 1)'($signed(mval)) + (AW + 1)'($signed(qv[s]));
        assign acc[s] = (tot > SHI) ? SHI[AW-1:0] :
                        (tot < SLO) ? SLO[AW-1:0] : tot[AW-1:0];
    end

    assign mix = $signed(acc[NSTG-1]);

endmodule

// File: rtl/frac_delay_filter.sv
module frac_delay_filter
    import fdf_pkg::*;
#(
    parameter int IN_W     = 12,
    parameter int NSTG     = 5,
    parameter int PRE_STEP = 1,
    parameter int CW       = 9,
    parameter int CFRAC    = 9,
    parameter int QW       = 11,
    parameter int OUT_W    = 12,
    parameter int GW       = 4,
    parameter int MF       = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  x_in,
    output logic [OUT_W-1:0] y_out
);

    localparam int DEPTH = (NSTG - 1) * PRE_STEP + NTAP - 1;

    typedef struct packed {
        logic signed [OUT_W-1:0] y;
    } top_t;

    top_t st_d, st_q;

    logic [DEPTH:0][IN_W-1:0] taps;
    logic [NSTG-1:0][QW-1:0]  qv;
    logic signed [OUT_W-1:0]  mix;

    fdf_delay_line #(.W(IN_W), .DEPTH(DEPTH)) u_dline (
        .clk  (clk),
        .rst  (rst),
        .din  (x_in),
        .taps (taps)
    );

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        localparam int PRE = s * PRE_STEP;
        logic signed [QW-1:0] qs;
        fdf_subfilter #(
            .W    (IN_W),
            .CW   (CW),
            .FRAC (CFRAC),
            .QW   (QW),
            .SYM  (stage_even(s))
        ) u_sub (
            .clk (clk),
            .rst (rst),
            .win (taps[PRE+NTAP-1:PRE]),
            .q   (qs)
        );
        assign qv[s] = qs;
    end

    fdf_combine #(
        .NSTG (NSTG),
        .QW   (QW),
        .AW   (OUT_W),
        .GW   (GW),
        .MF   (MF)
    ) u_comb (
        .qv  (qv),
        .mix (mix)
    );

    always_comb begin
        st_d   = st_q;
        st_d.y = mix;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign y_out = st_q.y;

endmodule

// File: rtl/frac_delay_filter_chk.sv
module frac_delay_filter_chk
    import fdf_pkg::*;
#(
    parameter int IN_W     = 12,
    parameter int OUT_W    = 12,
    parameter int NSTG     = 5,
    parameter int PRE_STEP = 1
) (
    input logic             clk,
    input logic             rst,
    input logic [IN_W-1:0]  x_in,
    input logic [OUT_W-1:0] y_out
);

    localparam int DEPTH = (NSTG - 1) * PRE_STEP + NTAP - 1;
    localparam int LIM   = DEPTH + 3;
    localparam int NW    = $clog2(LIM + 1);

    logic [NW-1:0]   zero_run, hold_run;
    logic [IN_W-1:0] x_prev;
    logic            any_nz;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_run <= '0;
            hold_run <= '0;
            x_prev   <= '0;
            any_nz   <= 1'b0;
        end else begin
            x_prev <= x_in;
            if (x_in != '0) begin
                zero_run <= '0;
                any_nz   <= 1'b1;
            end else if (zero_run < NW'(LIM)) begin
                zero_run <= zero_run + 1'b1;
            end
            if (x_in != x_prev) begin
                hold_run <= '0;
            end else if (hold_run < NW'(LIM)) begin
                hold_run <= hold_run + 1'b1;
            end
        end
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) rst |=> (y_out == '0));

    // R2
    cold_start_chk: assert property (@(posedge clk) disable iff (rst)
        !any_nz |-> (y_out == '0));

    // R3
    quiet_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (zero_run >= NW'(LIM)) |-> (y_out == '0));

    // R8
    hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_run >= NW'(LIM)) |-> $stable(y_out));

endmodule

bind frac_delay_filter frac_delay_filter_chk #(
    .IN_W     (IN_W),
    .OUT_W    (OUT_W),
    .NSTG     (NSTG),
    .PRE_STEP (PRE_STEP)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .x_in  (x_in),
    .y_out (y_out)
);

// File: tb/tb_frac_delay_filter.sv
module tb_frac_delay_filter;

    localparam int IN_W  = 12;
    localparam int OUT_W = 12;
    localparam int NSTG  = 5;
    localparam int PRE   = 1;

    logic             clk  = 1'b0;
    logic             rst  = 1'b1;
    logic [IN_W-1:0]  x_in = '0;
    logic [OUT_W-1:0] y_out;

    int total = 0;
    int bad   = 0;
    int hist[2048];
    int nsamp = 0;

    frac_delay_filter dut (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .y_out (y_out)
    );

    always #4 clk = ~clk;

    // ---------------- bit-true reference model ----------------
    function automatic int xat(int i);
        if (i < 0) return 0;
        return hist[i];
    endfunction

    function automatic longint clampv(longint v, longint lo, longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // R4: coefficient of tap k in stage s (over 512)
    function automatic int tapv(int s, int k);
        int b[4] = '{1, -8, 34, 156};
        if (k < 4) return b[k];
        return (s % 2 == 0) ? b[7-k] : -b[7-k];
    endfunction

    // R5: round half up at 9 fractional bits, clamp to 11 bits
    function automatic int qstage(int s, int n);
        longint acc = 0;
        for (int k = 0; k < 8; k++) begin
            acc += longint'(tapv(s, k)) * longint'(xat(n - s * PRE - k));
        end
        return int'(clampv((acc + 256) >>> 9, -1024, 1023));
    endfunction

    // R6, R7: nested combine with gains in quarters
    function automatic int model(int n);
        int g[4] = '{7, -2, 2, -1};
        longint a, m;
        if (n < 0) return 0;
        a = qstage(0, n);
        for (int s = 1; s < NSTG; s++) begin
            m = clampv((a * g[(s-1)%4] + 2) >>> 2, -2048, 2047);
            a = clampv(m + qstage(s, n), -2048, 2047);
        end
        return int'(a);
    endfunction

    // ---------------- helpers ----------------
    task automatic check(int exp, string tag, string what);
        int got;
        got = $signed(y_out);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: y_out=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    // Called just after a falling edge; the output then reflects sample nsamp-2.
    task automatic push(int v, string tag);
        check((nsamp >= 2) ? model(nsamp - 2) : 0, tag,
              $sformatf("sample %0d", nsamp - 2));
        x_in = IN_W'(v);
        hist[nsamp] = v;
        nsamp++;
        @(negedge clk);
    endtask

    task automatic flush(int n, string tag);
        repeat (n) push(0, tag);
    endtask

    task automatic do_reset(int junk);
        rst  = 1'b1;
        x_in = IN_W'(junk);
        @(negedge clk);
        check(0, "R1", "first reset edge");
        @(negedge clk);
        rst   = 1'b0;
        x_in  = '0;
        nsamp = 0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        do_reset(0);
        check(0, "R1", "reset state");
    endtask

    task automatic t_impulse_pos();
        push(2047, "R2 R4 R6");
        flush(18, "R3 R4 R6");
    endtask

    task automatic t_impulse_neg();
        do_reset(0);
        push(-2048, "R8 R4");
        flush(18, "R4 R5 R8");
    endtask

    task automatic t_half_round();
        do_reset(0);
        push(256, "R5");
        flush(16, "R5");
        push(-256, "R5");
        flush(16, "R5");
    endtask

    task automatic t_step();
        do_reset(0);
        repeat (30) push(2047, "R7 R5");
        flush(16, "R3 R7");
    endtask

    task automatic t_neg_step();
        do_reset(0);
        repeat (25) push(-2048, "R7 R8");
        flush(16, "R3 R7");
    endtask

    task automatic t_noise();
        logic [15:0] lfsr = 16'hACE1;
        do_reset(0);
        for (int i = 0; i < 150; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            push(int'($signed(lfsr[11:0])), "R6 R8");
        end
        flush(16, "R3 R6");
    endtask

    task automatic t_reset_mid();
        do_reset(0);
        for (int i = 0; i < 10; i++) push(1900 - i * 400, "R6");
        do_reset(-1500);
        push(1000, "R1 R3");
        flush(16, "R1 R3");
    endtask

    // ---------------- main ----------------
    initial begin
        @(negedge clk);
        t_reset_state();
        t_impulse_pos();
        t_impulse_neg();
        t_half_round();
        t_step();
        t_neg_step();
        t_noise();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule